// File: doc/BRIEF.md
# Sixteen-Line Maskable Interrupt Controller

This block collects sixteen maskable request lines and turns them into a single request to a processor core. Each line has a pending flag and an individual enable bit. One global mask bit gates every line at once. A one-cycle pulse on a line sets its pending flag. The flag stays set until software clears it or the core takes the interrupt. Software changes the pending flags, the enable bits and the global mask through an operation code and a bit mask. Each operation takes effect in one clock cycle.

Line index 0 is the first general line, and indices up to 13 are the other general lines. Index 14 is the data-log line and index 15 is the real-time-OS line. A line is offered to the core when its pending flag is set, its enable bit is set and the global mask is clear. When several lines qualify, the lowest index is offered. The block drives a request strobe together with that line's 4-bit index. An acknowledge from the core clears the offered line's pending flag. It also sets the global mask, so software must clear the mask again before a nested interrupt can be taken.

Top module: `irq_ctl_top`

## Requirements
- R1: After a synchronous reset, all pending flags are 0 and all enable bits are 0. The global mask is 1, the request strobe is low and the index is 0.
- R2: A 1 on `irq_in[i]` during a clock edge sets pending flag i. The flag stays set until it is cleared.
- R3: Operation code 1 sets the pending flags selected by the bit mask, and code 2 clears them. Unselected flags are unchanged.
- R4: Operation code 3 sets the enable bits selected by the bit mask, and code 4 clears them. Unselected bits are unchanged.
- R5: Operation code 5 sets the global mask to 1, which disables all lines. Code 6 clears it to 0, which enables them. Code 0 does nothing.
- R6: `req` is high exactly when at least one line has both its pending flag and its enable bit set while the global mask is 0.
- R7: While `req` is high, `req_idx` holds the lowest index whose pending flag and enable bit are both set. While `req` is low, it holds 0.
- R8: `ack` while `req` is high clears the pending flag at `req_idx` and sets the global mask to 1 on the same edge.
- R9: If a line pulse and a software clear of the same pending flag happen in the same cycle, the flag ends up set.
- R10: A request that arrives while its line or the global mask is disabled stays latched. It is offered once both are enabled.
- R11: `ack` while `req` is low changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Request pulses, one per line |
| sw_op | input | 3 | Software operation code (0 = none) |
| sw_mask | input | 16 | Bit mask that selects the lines the operation acts on |
| ack | input | 1 | Core acknowledge of the offered line |
| pend_q | output | 16 | Pending flags |
| en_q | output | 16 | Individual enable bits |
| gmask | output | 1 | Global mask (1 = all lines disabled) |
| req | output | 1 | Request to the core |
| req_idx | output | 4 | Index of the offered line |

## Verification
A sequence of vectors carries state from one step to the next. It first latches a request while the line is disabled and releases it by enabling the line and clearing the global mask. A second request then arrives on a lower index, which shows that priority follows the index and not the arrival order. The acknowledge is applied once while a line is offered and once while nothing is offered, which separates an acknowledge that is taken from one that is ignored. A line pulse is applied in the same cycle as a software clear of that line, and a mid-run reset is checked against the reset values.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
    localparam int NLINES = 16;
    localparam int IDX_W  = $clog2(NLINES);

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PSET   = 3'd1,
        OP_PCLR   = 3'd2,
        OP_ESET   = 3'd3,
        OP_ECLR   = 3'd4,
        OP_GDIS   = 3'd5,
        OP_GENA   = 3'd6
    } sw_op_e;

    typedef struct packed {
        logic [NLINES-1:0] set_v;
        logic [NLINES-1:0] clr_v;
    } bit_upd_t;

    function automatic bit_upd_t decode_upd(input sw_op_e op, input sw_op_e op_set,
                                            input sw_op_e op_clr,
                                            input logic [NLINES-1:0] m);
        bit_upd_t u;
        u.set_v = (op == op_set) ? m : '0;
        u.clr_v = (op == op_clr) ? m : '0;
        return u;
    endfunction
endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch
    import irq_ctl_pkg::*;
#(
    parameter int N = NLINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] hw_evt,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] sw_clr,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] pend_nxt;

    always_comb begin
        pend_nxt = ((pend | sw_set) & ~(sw_clr | ack_clr)) | hw_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= pend_nxt;
    end

    // R9
    hw_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|hw_evt) |=> ((pend & $past(hw_evt)) == $past(hw_evt)));
endmodule

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl
    import irq_ctl_pkg::*;
#(
    parameter int N = NLINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] en_set,
    input  logic [N-1:0] en_clr,
    input  logic         g_dis,
    input  logic         g_ena,
    input  logic         ack_take,
    output logic [N-1:0] en,
    output logic         gmask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en    <= '0;
            gmask <= 1'b1;
        end else begin
            en <= (en | en_set) & ~en_clr;
            if (ack_take || g_dis) gmask <= 1'b1;
            else if (g_ena)        gmask <= 1'b0;
        end
    end

    // R8
    ack_masks_chk: assert property (@(posedge clk) disable iff (rst)
        ack_take |=> gmask);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_ctl_pkg::*;
#(
    parameter int N  = NLINES,
    parameter int IW = IDX_W
) (
    input  logic [N-1:0]  live,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic [N-1:0] below;
    logic [N-1:0] grant;

    assign below[0] = 1'b0;
    genvar g;
    generate
        for (g = 1; g < N; g++) begin : g_chain
            assign below[g] = below[g-1] | live[g-1];
        end
        for (g = 0; g < N; g++) begin : g_grant
            assign grant[g] = live[g] & ~below[g];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++)
            if (grant[i]) idx = idx | IW'(i);
    end

    assign any = |live;

    // R7
    one_grant_chk: assert final ($onehot0(grant));
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
    import irq_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] irq_in,
    input  logic [2:0]        sw_op,
    input  logic [NLINES-1:0] sw_mask,
    input  logic              ack,
    output logic [NLINES-1:0] pend_q,
    output logic [NLINES-1:0] en_q,
    output logic              gmask,
    output logic              req,
    output logic [IDX_W-1:0]  req_idx
);
    sw_op_e      op;
    bit_upd_t    p_upd, e_upd;
    logic        ack_take;
    logic [NLINES-1:0] ack_clr;
    logic [NLINES-1:0] live;

    assign op       = sw_op_e'(sw_op);
    assign p_upd    = decode_upd(op, OP_PSET, OP_PCLR, sw_mask);
    assign e_upd    = decode_upd(op, OP_ESET, OP_ECLR, sw_mask);
    assign ack_take = ack & req;
    assign ack_clr  = ack_take ? (NLINES'(1) << req_idx) : '0;
    assign live     = pend_q & en_q & {NLINES{~gmask}};

    irq_pend_latch #(.N(NLINES)) u_pend (
        .clk(clk), .rst(rst), .hw_evt(irq_in),
        .sw_set(p_upd.set_v), .sw_clr(p_upd.clr_v),
        .ack_clr(ack_clr), .pend(pend_q)
    );

    irq_mask_ctl #(.N(NLINES)) u_mask (
        .clk(clk), .rst(rst),
        .en_set(e_upd.set_v), .en_clr(e_upd.clr_v),
        .g_dis(op == OP_GDIS), .g_ena(op == OP_GENA),
        .ack_take(ack_take), .en(en_q), .gmask(gmask)
    );

    irq_prio_enc #(.N(NLINES), .IW(IDX_W)) u_prio (
        .live(live), .any(req), .idx(req_idx)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (pend_q == '0 && en_q == '0 && gmask));

    // R6
    req_gate_chk: assert property (@(posedge clk) disable iff (rst)
        req |-> (!gmask && pend_q[req_idx] && en_q[req_idx]));

    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && req && !irq_in[req_idx]) |=> !pend_q[$past(req_idx)]);

    // R11
    idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !req && sw_op == 3'd0 && irq_in == '0) |=>
            ($stable(pend_q) && $stable(en_q) && $stable(gmask)));
endmodule

// File: tb/irq_ctl_top_test.sv
module irq_ctl_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    // {irq, op, mask, ack, exp_pend, exp_en, exp_gm, exp_req, exp_idx}
    localparam logic [73:0] VEC [NV] = '{
        {16'h0008, 3'd0, 16'h0000, 1'b0, 16'h0008, 16'h0000, 1'b1, 1'b0, 4'd0},  // R2 R10
        {16'h0000, 3'd3, 16'h000C, 1'b0, 16'h0008, 16'h000C, 1'b1, 1'b0, 4'd0},  // R4 R10
        {16'h0000, 3'd6, 16'h0000, 1'b0, 16'h0008, 16'h000C, 1'b0, 1'b1, 4'd3},  // R5 R6 R10
        {16'h0004, 3'd0, 16'h0000, 1'b0, 16'h000C, 16'h000C, 1'b0, 1'b1, 4'd2},  // R7
        {16'h0000, 3'd0, 16'h0000, 1'b1, 16'h0008, 16'h000C, 1'b1, 1'b0, 4'd0},  // R8
        {16'h0000, 3'd6, 16'h0000, 1'b0, 16'h0008, 16'h000C, 1'b0, 1'b1, 4'd3},  // R5
        {16'h0000, 3'd1, 16'h8001, 1'b0, 16'h8009, 16'h000C, 1'b0, 1'b1, 4'd3},  // R3
        {16'h0000, 3'd3, 16'h8000, 1'b0, 16'h8009, 16'h800C, 1'b0, 1'b1, 4'd3},  // R4
        {16'h0000, 3'd2, 16'h0008, 1'b0, 16'h8001, 16'h800C, 1'b0, 1'b1, 4'd15}, // R3 R7
        {16'h0001, 3'd2, 16'h0001, 1'b0, 16'h8001, 16'h800C, 1'b0, 1'b1, 4'd15}, // R9
        {16'h0000, 3'd4, 16'h8000, 1'b0, 16'h8001, 16'h000C, 1'b0, 1'b0, 4'd0},  // R4 R6
        {16'h0000, 3'd0, 16'h0000, 1'b1, 16'h8001, 16'h000C, 1'b0, 1'b0, 4'd0},  // R11
        {16'h0000, 3'd5, 16'h0000, 1'b0, 16'h8001, 16'h000C, 1'b1, 1'b0, 4'd0}   // R5
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq_in = '0;
    logic [2:0]  sw_op = '0;
    logic [15:0] sw_mask = '0;
    logic        ack = 1'b0;
    logic [15:0] pend_q, en_q;
    logic        gmask, req;
    logic [3:0]  req_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ctl_top uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .sw_op(sw_op),
        .sw_mask(sw_mask), .ack(ack), .pend_q(pend_q), .en_q(en_q),
        .gmask(gmask), .req(req), .req_idx(req_idx)
    );

    task automatic check(input string tag, input logic [37:0] act, input logic [37:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got pend=%h en=%h gm=%b req=%b idx=%0d, expected pend=%h en=%h gm=%b req=%b idx=%0d",
                     tag, act[37:22], act[21:6], act[5], act[4], act[3:0],
                     exp[37:22], exp[21:6], exp[5], exp[4], exp[3:0]);
        end
    endtask

    function automatic logic [37:0] outs();
        return {pend_q, en_q, gmask, req, req_idx};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 reset", outs(), {16'h0, 16'h0, 1'b1, 1'b0, 4'd0});
        for (int i = 0; i < NV; i++) begin
            {irq_in, sw_op, sw_mask, ack} = VEC[i][73:38];
            @(negedge clk);
            irq_in = '0; sw_op = '0; sw_mask = '0; ack = 1'b0;
            check($sformatf("R2-R11 vector %0d", i), outs(), VEC[i][37:0]);
        end
        // R10: latched line 0 released by its enable and the global enable
        sw_op = 3'd3; sw_mask = 16'h0001;
        @(negedge clk);
        sw_op = 3'd6; sw_mask = '0;
        @(negedge clk);
        sw_op = '0;
        check("R10 release", outs(), {16'h8001, 16'h000D, 1'b0, 1'b1, 4'd0});
        // R8 ack of line 0 with a simultaneous global enable: mask still set
        ack = 1'b1; sw_op = 3'd6;
        @(negedge clk);
        ack = 1'b0; sw_op = '0;
        check("R8 ack over enable", outs(), {16'h8000, 16'h000D, 1'b1, 1'b0, 4'd0});
        // R1 mid-run reset
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid-run reset", outs(), {16'h0, 16'h0, 1'b1, 1'b0, 4'd0});
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule